// File: doc/BRIEF.md
# Tuning Window Tap Selector

After a sampling-phase sweep has probed every delay tap twice, this block picks the tap at the middle of the widest stretch of passing results. It takes two result vectors that are 2N bits wide, where N is the live tap count. Bit i and bit i±N describe the same tap. One vector holds the pass/fail results of the tuning commands. The other holds the results of the sample-compare circuit. The block first folds the two probes of each tap into one verdict. It then chooses which vector to search and walks that vector one bit per clock. The chosen tap is loaded into a result register, and an automatic re-tune enable is raised afterwards.

This interface carries no stream of data items. `start` is a plain control strobe and the results are plain status pins, so there is no valid/ready pairing and no back-pressure. A `start` seen while a search is running is dropped. The result vectors and the tap count are captured on the accepted `start` edge, and the caller may change them after that edge.

Top module: `tap_window_select`

## Requirements
- R1: After reset, `done`, `fail` and `retune_en` are low and `sel_tap` is 0.
- R2: Before the search, bit i of the tuning vector (0 ≤ i < 2N) counts as passing only if bit i and its partner bit (i+N when i < N, otherwise i−N) are both 1. A failure in either probe therefore removes both probes of that tap.
- R3: The same pairwise folding is applied to the sample-compare vector.
- R4: The search covers indices 0 to 2N−1 only and does not wrap around. Input bits at index 2N and above have no effect.
- R5: The search finds the longest contiguous run of passing bits. When two runs have equal length, the lower-indexed run wins.
- R6: With the run spanning indices s to e−1, the selected tap is ((s+e)/2) mod N, where the division truncates.
- R7: If every folded tuning bit in 0..2N−1 is 1, the search uses the folded sample-compare vector and a run of length 1 is enough. Otherwise it uses the folded tuning vector and needs a run of at least 3.
- R8: If the best run is shorter than the required length, `fail` rises together with `done`, `sel_tap` keeps its previous value and `retune_en` stays low.
- R9: On success, `sel_tap` takes the new value one cycle before the `done` pulse. `retune_en` rises in the `done` cycle, and `fail` stays low.
- R10: A tap count of 0 ends with `done` and `fail` one cycle after `start`, and `sel_tap` is unchanged.
- R11: `done` is high for exactly one cycle. `sel_tap`, `fail` and `retune_en` hold their values until the next accepted `start`. A `start` that arrives while a search is running is ignored.
- R12: Counting the clock edge that accepts `start` as edge 0, `done` goes high after edge 2N+3 on success and after edge 2N+2 on failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe. It is accepted only when the block is idle. |
| tap_count | input | $clog2(MAX_TAPS+1) | Live tap count N, from 0 to MAX_TAPS |
| tune_ok | input | 2*MAX_TAPS | Tuning-command pass bits, with probe index i at bit i |
| cmp_ok | input | 2*MAX_TAPS | Sample-compare pass bits, with probe index i at bit i |
| sel_tap | output | max(1,$clog2(MAX_TAPS)) | Selected tap |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | The last search found no usable window |
| retune_en | output | 1 | Automatic re-tune enable, raised after a successful selection |

## Verification
On a successful search, the tap write, the `done` pulse and the rise of `retune_en` are bunched into two adjacent cycles. The ordering between them is the part most likely to go wrong. A scoreboard monitor captures `sel_tap` and `retune_en` on every falling edge. In the `done` cycle it checks that the tap already carried the expected value one sample earlier, while `retune_en` was still low, and that `retune_en` is high in the `done` cycle itself. A second overlap is provoked on purpose: a new `start` with different vectors is pulsed in the middle of a scan. That case passes only if exactly one `done` appears and it carries the result of the first request.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE,
    ST_SCAN,
    ST_DECIDE,
    ST_COMMIT
  } sel_state_e;

  // Required run lengths for the two search sources
  localparam int unsigned MIN_RUN_TUNE = 3;
  localparam int unsigned MIN_RUN_CMP  = 1;

endpackage

// File: rtl/tap_pair_merge.sv
// Folds the two probes of each tap into one verdict and flags a fully passing vector.
module tap_pair_merge #(
  parameter  int unsigned MAX_TAPS = 16,
  localparam int unsigned VEC_W    = 2 * MAX_TAPS,
  localparam int unsigned NUM_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic [NUM_W-1:0] num_taps,
  input  logic [VEC_W-1:0] raw,
  output logic [VEC_W-1:0] folded,
  output logic             all_set
);

  logic [VEC_W-1:0] lo_mask;   // indices [0, N)
  logic [VEC_W-1:0] live_mask; // indices [0, 2N)
  logic [VEC_W-1:0] hi_mask;   // indices [N, 2N)
  logic [VEC_W-1:0] partner;

  always_comb begin
    lo_mask   = (VEC_W'(1) << num_taps) - VEC_W'(1);
    live_mask = (VEC_W'(1) << {num_taps, 1'b0}) - VEC_W'(1);
    hi_mask   = live_mask & ~lo_mask;
    // lower copy looks N up, upper copy looks N down
    partner   = ((raw >> num_taps) & lo_mask) | ((raw << num_taps) & hi_mask);
    folded    = raw & partner & live_mask;
    all_set   = &(folded | ~live_mask);
  end

endmodule

// File: rtl/run_tracker.sv
// Walks a bit stream one bit per step, keeping the first longest run of ones.
module run_tracker #(
  parameter  int unsigned VEC_W = 32,
  localparam int unsigned IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1,
  localparam int unsigned LEN_W = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_in,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(VEC_W);

  logic [LEN_W-1:0] run_len;
  logic [IDX_W-1:0] run_start;
  logic [LEN_W-1:0] ext_len;
  logic [IDX_W-1:0] ext_start;

  always_comb begin
    ext_len   = (run_len == LEN_MAX) ? LEN_MAX : run_len + LEN_W'(1);
    ext_start = (run_len == '0) ? idx : run_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len    <= '0;
      run_start  <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (clear) begin
      run_len    <= '0;
      run_start  <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (step) begin
      if (bit_in) begin
        run_len   <= ext_len;
        run_start <= ext_start;
        // strictly longer only: an equal later run never displaces an earlier one
        if (ext_len > best_len) begin
          best_len   <= ext_len;
          best_start <= ext_start;
        end
      end else begin
        run_len <= '0;
      end
    end
  end

  // R5: the recorded best can never be shorter than the run in progress
  a_r5_best_covers_run: assert property (@(posedge clk) disable iff (!rst_n)
    best_len >= run_len);

  // R4: a run cannot start after the index that extends it
  a_r4_start_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bit_in && !clear) |-> (ext_start <= idx));

endmodule

// File: rtl/tap_window_select.sv
module tap_window_select
  import tap_sel_pkg::*;
#(
  parameter  int unsigned MAX_TAPS = 16,
  localparam int unsigned VEC_W    = 2 * MAX_TAPS,
  localparam int unsigned NUM_W    = $clog2(MAX_TAPS + 1),
  localparam int unsigned TAP_W    = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] tap_count,
  input  logic [VEC_W-1:0] tune_ok,
  input  logic [VEC_W-1:0] cmp_ok,
  output logic [TAP_W-1:0] sel_tap,
  output logic             done,
  output logic             fail,
  output logic             retune_en
);

  localparam int unsigned IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1;
  localparam int unsigned LEN_W = $clog2(VEC_W + 1);
  localparam int unsigned SUM_W = IDX_W + 2 > LEN_W + 1 ? IDX_W + 2 : LEN_W + 1;

  sel_state_e       state;
  logic [NUM_W-1:0] num_q;
  logic [VEC_W-1:0] tune_q, cmp_q, search_q;
  logic [LEN_W-1:0] need_q;
  logic [IDX_W-1:0] idx_q;

  logic [VEC_W-1:0] tune_fold, cmp_fold;
  logic             tune_full, cmp_full_unused;

  logic [IDX_W-1:0] best_start;
  logic [LEN_W-1:0] best_len;
  logic             accept, scan_clear, scan_step, last_bit;
  logic [LEN_W-1:0] last_idx;
  logic [SUM_W-1:0] mid_sum;
  logic [SUM_W-2:0] mid_half;
  logic [TAP_W-1:0] mid_tap;
  logic             window_ok;

  tap_pair_merge #(.MAX_TAPS(MAX_TAPS)) u_fold_tune (
    .num_taps (num_q),
    .raw      (tune_q),
    .folded   (tune_fold),
    .all_set  (tune_full)
  );

  tap_pair_merge #(.MAX_TAPS(MAX_TAPS)) u_fold_cmp (
    .num_taps (num_q),
    .raw      (cmp_q),
    .folded   (cmp_fold),
    .all_set  (cmp_full_unused)
  );

  run_tracker #(.VEC_W(VEC_W)) u_runs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (scan_clear),
    .step       (scan_step),
    .bit_in     (search_q[idx_q]),
    .idx        (idx_q),
    .best_start (best_start),
    .best_len   (best_len)
  );

  always_comb begin
    accept     = (state == ST_IDLE) && start;
    scan_clear = accept;
    scan_step  = (state == ST_SCAN);
    last_idx   = LEN_W'({num_q, 1'b0}) - LEN_W'(1);
    last_bit   = (LEN_W'(idx_q) == last_idx);
    // (s + e) / 2 with e = s + len, folded once into [0, N)
    mid_sum    = SUM_W'({best_start, 1'b0}) + SUM_W'(best_len);
    mid_half   = mid_sum[SUM_W-1:1];
    if (mid_half >= (SUM_W-1)'(num_q))
      mid_tap = TAP_W'(mid_half - (SUM_W-1)'(num_q));
    else
      mid_tap = TAP_W'(mid_half);
    window_ok  = (num_q != '0) && (best_len >= need_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      num_q     <= '0;
      tune_q    <= '0;
      cmp_q     <= '0;
      search_q  <= '0;
      need_q    <= '0;
      idx_q     <= '0;
      sel_tap   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      retune_en <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            num_q     <= tap_count;
            tune_q    <= tune_ok;
            cmp_q     <= cmp_ok;
            fail      <= 1'b0;
            retune_en <= 1'b0;
            state     <= (tap_count == '0) ? ST_DECIDE : ST_MERGE;
          end
        end
        ST_MERGE: begin
          if (tune_full) begin
            search_q <= cmp_fold;
            need_q   <= LEN_W'(MIN_RUN_CMP);
          end else begin
            search_q <= tune_fold;
            need_q   <= LEN_W'(MIN_RUN_TUNE);
          end
          idx_q <= '0;
          state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (last_bit) state <= ST_DECIDE;
          else          idx_q <= idx_q + IDX_W'(1);
        end
        ST_DECIDE: begin
          if (window_ok) begin
            sel_tap <= mid_tap;
            state   <= ST_COMMIT;
          end else begin
            fail  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_COMMIT: begin
          retune_en <= 1'b1;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: re-tune enable comes up only with a successful completion, after the tap settled
  a_r9_retune_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retune_en) |-> (done && !fail && $stable(sel_tap)));

  // R8: a failed search leaves the tap alone and no re-tune
  a_r8_fail_keeps_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($stable(sel_tap) && !retune_en && done));

  // R4: the scan index never leaves 0..2N-1
  a_r4_scan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN) |-> (LEN_W'(idx_q) <= last_idx && num_q != '0));

  // R11: a start during a search leaves the captured tap count alone
  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> $stable(num_q));

endmodule

// File: tb/tap_window_select_tb.sv
`timescale 1ns/1ps
module tap_window_select_tb;

  localparam int MAXT = 16;
  localparam int VW   = 2 * MAXT;
  localparam int NW   = $clog2(MAXT + 1);
  localparam int TW   = $clog2(MAXT);

  typedef struct {
    int    tap;
    bit    fl;
    bit    rt;
    int    lat;
    int    t0;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] tap_count = '0;
  logic [VW-1:0] tune_ok = '0;
  logic [VW-1:0] cmp_ok = '0;
  logic [TW-1:0] sel_tap;
  logic          done, fail, retune_en;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  int   last_tap = 0;
  bit   finished = 1'b0;
  int   prev_tap = 0;
  bit   prev_rt = 1'b0;

  tap_window_select #(.MAX_TAPS(MAXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
    .tune_ok(tune_ok), .cmp_ok(cmp_ok), .sel_tap(sel_tap),
    .done(done), .fail(fail), .retune_en(retune_en)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference: fold probes, choose source, collect runs at their ends
  function automatic exp_t model(input int n, input logic [VW-1:0] t, input logic [VW-1:0] c);
    exp_t e;
    bit ft[VW];
    bit fc[VW];
    bit full;
    int need, bs, be, blen, rs;
    e.tag = "";
    e.t0  = 0;
    if (n == 0) begin
      e.fl = 1; e.rt = 0; e.tap = last_tap; e.lat = 2;
      return e;
    end
    full = 1;
    for (int i = 0; i < 2 * n; i++) begin
      int p = (i < n) ? i + n : i - n;
      ft[i] = t[i] && t[p];
      fc[i] = c[i] && c[p];
      if (!ft[i]) full = 0;
    end
    need = full ? 1 : 3;
    blen = 0; bs = 0; be = 0; rs = -1;
    for (int i = 0; i <= 2 * n; i++) begin
      bit v = (i < 2 * n) ? (full ? fc[i] : ft[i]) : 1'b0;
      if (v && rs < 0) rs = i;
      if (!v && rs >= 0) begin
        if (i - rs > blen) begin blen = i - rs; bs = rs; be = i; end
        rs = -1;
      end
    end
    if (blen >= need) begin
      e.fl = 0; e.rt = 1; e.tap = ((bs + be) / 2) % n; e.lat = 2 * n + 4;
    end else begin
      e.fl = 1; e.rt = 0; e.tap = last_tap; e.lat = 2 * n + 3;
    end
    return e;
  endfunction

  // Driver: push the expected outcome, fire start, wait for the monitor to consume it
  task automatic run_case(input int n, input logic [VW-1:0] t, input logic [VW-1:0] c,
                          input string tag, input bit busy_poke);
    exp_t e;
    e = model(n, t, c);
    e.tag = tag;
    @(negedge clk);
    tap_count = NW'(n); tune_ok = t; cmp_ok = c; start = 1'b1;
    e.t0 = cyc;
    q.push_back(e);
    if (!e.fl) last_tap = e.tap;
    @(negedge clk);
    start = 1'b0;
    if (busy_poke) begin
      repeat (4) @(negedge clk);
      tap_count = NW'(3); tune_ok = '1; cmp_ok = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
    // R11: results hold after the pulse
    check(sel_tap == TW'(e.tap), {"R11 hold tap ", tag}, int'(sel_tap), e.tap);
    check(fail == e.fl && retune_en == e.rt && !done, {"R11 hold flags ", tag},
          int'({done, fail, retune_en}), int'({1'b0, e.fl, e.rt}));
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(fail == e.fl, {"R7/R8/R10 fail flag ", e.tag}, int'(fail), int'(e.fl));
          check(sel_tap == TW'(e.tap), {"R5/R6 tap ", e.tag}, int'(sel_tap), e.tap);
          check(retune_en == e.rt, {"R9 retune ", e.tag}, int'(retune_en), int'(e.rt));
          check(cyc - e.t0 == e.lat, {"R12 latency ", e.tag}, cyc - e.t0, e.lat);
          if (!e.fl)
            check(prev_tap == e.tap && !prev_rt, {"R9 tap before retune ", e.tag},
                  prev_tap, e.tap);
        end
      end
      prev_tap = int'(sel_tap);
      prev_rt  = retune_en;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] t, c;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !fail && !retune_en, "R1 flags at reset", int'({done, fail, retune_en}), 0);
    check(sel_tap == '0, "R1 tap at reset", int'(sel_tap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fail && !retune_en && sel_tap == '0, "R1 after release",
          int'({done, fail, retune_en}), 0);

    // R2: failing first probe of tap 2 removes both copies
    run_case(8, VW'(32'h0000_FFFB), '0, "R2 first copy", 1'b0);
    // R2: failing second probe of tap 2 gives the same answer
    run_case(8, VW'(32'h0000_FBFF), '0, "R2 second copy", 1'b0);
    // R7/R3: all tuning pass, compare has a single passing tap -> run of 1 accepted
    run_case(8, VW'(32'h0000_FFFF), VW'(32'h0000_2020), "R7 compare min1", 1'b0);
    // R3: compare copy of tap 6 failing clears both; two length-4 runs, first wins (R5)
    run_case(8, VW'(32'h0000_FFFF), VW'(32'h0000_3C7C), "R3 compare fold", 1'b0);
    // R7: runs of two only -> fail, tap kept (R8)
    run_case(8, VW'(32'h0000_0303), '1, "R7 R8 run of two", 1'b0);
    // R7: run of exactly three is enough
    run_case(8, VW'(32'h0000_3838), '0, "R7 run of three", 1'b0);
    // R5: several equal runs, earliest chosen
    run_case(8, VW'(32'h0000_7777), '0, "R5 tie", 1'b0);
    // R4: bits above 2N are ignored
    run_case(4, VW'(32'hFFFF_FF77), '0, "R4 upper bits", 1'b0);
    // R6: window straddling N folds back with modulo
    run_case(8, VW'(32'h0000_C3C3), '0, "R6 modulo", 1'b0);
    // R10: zero taps
    run_case(0, '1, '1, "R10 zero taps", 1'b0);
    // R8 again after a success: previous tap must survive
    run_case(16, VW'(32'h0003_0003), '0, "R8 keep tap", 1'b0);
    // R11: start during a scan is ignored
    run_case(16, VW'(32'h0FF0_0FF0), '0, "R11 busy start", 1'b1);
    // R4: full width, all pass in both -> compare vector over 32 bits
    run_case(16, '1, VW'(32'h00F8_00F8), "R4 full width", 1'b0);
    for (int k = 0; k < 24; k++) begin
      int n = 1 + ($urandom % MAXT);
      t = VW'($urandom) | VW'($urandom);
      c = VW'($urandom);
      if (k % 4 == 0) t = '1;
      run_case(n, t, c, "R2 R5 R6 R7 random", 1'b0);
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule